// File: doc/BRIEF.md
# Tag-Snooping Reservation Station

This block holds micro-ops that have been decoded and renamed but have not yet executed. Each occupied slot stores an operation code, the reorder-buffer tag of the result, and two source operands. Each operand is either ready, holding its value, or waiting, holding the tag of the micro-op that will produce it. A writeback bus carries a valid strobe, a tag and a value. Every waiting operand whose tag matches a valid broadcast takes the value and becomes ready. This happens in the same cycle that the reorder buffer sees the broadcast.

A micro-op may dispatch to the single execution port when both of its operands are ready. In each cycle the oldest such micro-op is presented on the dispatch outputs, and its slot is released at the next clock edge. The decoder can insert one micro-op per cycle. When all slots are occupied, the full output stalls it.

An operand that is inserted in the same cycle as a broadcast of its producer's tag takes the broadcast value on insertion. This means a result is never lost in the gap between rename and the write into the station.

Top module: `rsv_station`

## Requirements
- R1: After reset the station is empty: `full` is 0 and `dispValid` is 0.
- R2: A micro-op inserted with both operands ready appears on the dispatch outputs in the cycle after insertion, with its opcode, destination tag and both operand values unchanged.
- R3: A waiting operand takes `wbData` and becomes ready only in a cycle where `wbValid` is 1 and `wbTag` equals its stored producer tag. A broadcast with a different tag, or with `wbValid` at 0, leaves it waiting.
- R4: A micro-op with any operand still waiting is never presented for dispatch.
- R5: If an operand is inserted waiting and a matching broadcast occurs in the same cycle, the stored operand is ready and holds the broadcast value. The micro-op can then dispatch in the next cycle.
- R6: When several micro-ops are eligible, the one inserted earliest is dispatched first, whatever slot it occupies. Insertion always uses the lowest-numbered free slot.
- R7: At most one micro-op is dispatched per cycle. A dispatched micro-op leaves the station at the next clock edge and is never presented again.
- R8: `full` is 1 exactly when all 4 slots are occupied. An insert request while `full` is 1 is dropped and never reaches the dispatch outputs. `full` falls after a dispatch frees a slot.
- R9: One broadcast wakes every waiting operand in the station that holds the matching tag, in all slots and in either operand position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| insValid | input | 1 | Insert request from the decoder |
| insOp | input | 4 | Operation code of the inserted micro-op |
| insDstTag | input | 5 | Reorder-buffer tag of the result |
| insSrcARdy | input | 1 | Operand A is already available |
| insSrcAVal | input | 16 | Operand A value (used when ready) |
| insSrcATag | input | 5 | Operand A producer tag (used when waiting) |
| insSrcBRdy | input | 1 | Operand B is already available |
| insSrcBVal | input | 16 | Operand B value (used when ready) |
| insSrcBTag | input | 5 | Operand B producer tag (used when waiting) |
| wbValid | input | 1 | Writeback broadcast present |
| wbTag | input | 5 | Tag of the broadcast result |
| wbData | input | 16 | Value of the broadcast result |
| full | output | 1 | All slots occupied; stall the decoder |
| dispValid | output | 1 | A micro-op is dispatched this cycle |
| dispOp | output | 4 | Dispatched operation code |
| dispDstTag | output | 5 | Dispatched destination tag |
| dispSrcA | output | 16 | Dispatched operand A value |
| dispSrcB | output | 16 | Dispatched operand B value |

## Verification
Insertion and wakeup can happen in the same cycle. The bench drives an insert whose waiting operand names the tag on the writeback bus in that cycle, and then expects the micro-op at the dispatch port one cycle later with the broadcast value. Wakeup and age selection also meet when one broadcast releases two waiters at once. The two waiters are placed so that the older one sits in the higher slot, and the bench judges the dispatch order and both captured values. A third collision is an insert attempted against a full station while entries drain: the dropped micro-op must never appear at the port.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  parameter int unsigned RS_ENTRIES = 4;
  parameter int unsigned OP_W       = 4;
  parameter int unsigned TAG_W      = 5;
  parameter int unsigned DATA_W     = 16;
  localparam int unsigned IDX_W     = (RS_ENTRIES > 1) ? $clog2(RS_ENTRIES) : 1;

  typedef struct packed {
    logic              rdy;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] val;
  } operand_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic             insEn;
    logic [IDX_W-1:0] insIdx;
    logic             dispEn;
    logic [IDX_W-1:0] dispIdx;
  } rsStrobe_t;

  // A waiting operand picks up a matching broadcast
  function automatic operand_t snoop(operand_t o, logic v, logic [TAG_W-1:0] t,
                                     logic [DATA_W-1:0] d);
    operand_t r = o;
    if (!o.rdy && v && (o.tag == t)) begin
      r.rdy = 1'b1;
      r.val = d;
    end
    return r;
  endfunction
endpackage

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  insValid,
  input  logic [RS_ENTRIES-1:0] bothRdy,
  output logic [RS_ENTRIES-1:0] validVec,
  output logic                  full,
  output rsStrobe_t             strobe
);
  // olderThan[j][i] set: slot j was inserted before slot i
  logic [RS_ENTRIES-1:0] olderThan [RS_ENTRIES];
  logic [RS_ENTRIES-1:0] eligible, winner;
  logic [IDX_W-1:0]      freeIdx, pickIdx;

  assign full     = &validVec;
  assign eligible = validVec & bothRdy;

  always_comb begin
    freeIdx = '0;
    for (int i = RS_ENTRIES - 1; i >= 0; i--)
      if (!validVec[i]) freeIdx = IDX_W'(i);
  end

  always_comb begin
    for (int i = 0; i < RS_ENTRIES; i++) begin
      winner[i] = eligible[i];
      for (int j = 0; j < RS_ENTRIES; j++)
        if (j != i && eligible[j] && olderThan[j][i]) winner[i] = 1'b0;
    end
    pickIdx = '0;
    for (int i = RS_ENTRIES - 1; i >= 0; i--)
      if (winner[i]) pickIdx = IDX_W'(i);
  end

  always_comb begin
    strobe.insEn   = insValid && !full;
    strobe.insIdx  = freeIdx;
    strobe.dispEn  = |eligible;
    strobe.dispIdx = pickIdx;
  end

  for (genvar k = 0; k < RS_ENTRIES; k++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validVec[k]  <= 1'b0;
        olderThan[k] <= '0;
      end else begin
        if (strobe.insEn && strobe.insIdx == IDX_W'(k)) begin
          validVec[k]  <= 1'b1;
          olderThan[k] <= '0;
        end else begin
          if (strobe.dispEn && strobe.dispIdx == IDX_W'(k)) validVec[k] <= 1'b0;
          if (strobe.insEn) olderThan[k][strobe.insIdx] <= validVec[k];
        end
      end
    end
  end
endmodule

// File: rtl/rsv_data.sv
module rsv_data
  import rsv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  rsStrobe_t             strobe,
  input  logic [OP_W-1:0]       insOp,
  input  logic [TAG_W-1:0]      insDstTag,
  input  operand_t              insA,
  input  operand_t              insB,
  input  logic                  wbValid,
  input  logic [TAG_W-1:0]      wbTag,
  input  logic [DATA_W-1:0]     wbData,
  output logic [RS_ENTRIES-1:0] bothRdy,
  output logic [OP_W-1:0]       dispOp,
  output logic [TAG_W-1:0]      dispDstTag,
  output logic [DATA_W-1:0]     dispSrcA,
  output logic [DATA_W-1:0]     dispSrcB
);
  logic [OP_W-1:0]  opQ  [RS_ENTRIES];
  logic [TAG_W-1:0] dstQ [RS_ENTRIES];
  operand_t         aQ   [RS_ENTRIES];
  operand_t         bQ   [RS_ENTRIES];

  for (genvar k = 0; k < RS_ENTRIES; k++) begin : g_entry
    assign bothRdy[k] = aQ[k].rdy && bQ[k].rdy;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opQ[k]  <= '0;
        dstQ[k] <= '0;
        aQ[k]   <= '0;
        bQ[k]   <= '0;
      end else if (strobe.insEn && strobe.insIdx == IDX_W'(k)) begin
        opQ[k]  <= insOp;
        dstQ[k] <= insDstTag;
        aQ[k]   <= snoop(insA, wbValid, wbTag, wbData);
        bQ[k]   <= snoop(insB, wbValid, wbTag, wbData);
      end else begin
        aQ[k]   <= snoop(aQ[k], wbValid, wbTag, wbData);
        bQ[k]   <= snoop(bQ[k], wbValid, wbTag, wbData);
      end
    end
  end

  assign dispOp     = opQ[strobe.dispIdx];
  assign dispDstTag = dstQ[strobe.dispIdx];
  assign dispSrcA   = aQ[strobe.dispIdx].val;
  assign dispSrcB   = bQ[strobe.dispIdx].val;
endmodule

// File: rtl/rsv_station.sv
module rsv_station
  import rsv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [OP_W-1:0]   insOp,
  input  logic [TAG_W-1:0]  insDstTag,
  input  logic              insSrcARdy,
  input  logic [DATA_W-1:0] insSrcAVal,
  input  logic [TAG_W-1:0]  insSrcATag,
  input  logic              insSrcBRdy,
  input  logic [DATA_W-1:0] insSrcBVal,
  input  logic [TAG_W-1:0]  insSrcBTag,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbData,
  output logic              full,
  output logic              dispValid,
  output logic [OP_W-1:0]   dispOp,
  output logic [TAG_W-1:0]  dispDstTag,
  output logic [DATA_W-1:0] dispSrcA,
  output logic [DATA_W-1:0] dispSrcB
);
  rsStrobe_t             strobe;
  logic [RS_ENTRIES-1:0] bothRdy, validVec;
  operand_t              insA, insB;

  assign insA      = '{rdy: insSrcARdy, tag: insSrcATag, val: insSrcAVal};
  assign insB      = '{rdy: insSrcBRdy, tag: insSrcBTag, val: insSrcBVal};
  assign dispValid = strobe.dispEn;

  rsv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .bothRdy(bothRdy),
    .validVec(validVec), .full(full), .strobe(strobe)
  );

  rsv_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insOp(insOp), .insDstTag(insDstTag),
    .insA(insA), .insB(insB), .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData),
    .bothRdy(bothRdy), .dispOp(dispOp), .dispDstTag(dispDstTag),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB)
  );
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk
  import rsv_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  insValid,
  input logic                  full,
  input logic                  dispValid,
  input logic [RS_ENTRIES-1:0] validVec,
  input logic [RS_ENTRIES-1:0] bothRdy,
  input rsStrobe_t             strobe
);
  logic [IDX_W:0] occ;
  logic [RS_ENTRIES-1:0] dispOneHot;
  assign dispOneHot = dispValid ? (RS_ENTRIES'(1) << strobe.dispIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else occ <= occ + (IDX_W+1)'(insValid && !full) - (IDX_W+1)'(dispValid);
  end

  // R8: full follows the occupancy seen at the ports
  a_r8_full_tracks_occupancy: assert property (@(posedge clk) disable iff (!rstN)
    full == (occ == (IDX_W+1)'(RS_ENTRIES)));
  // R8: occupancy never exceeds the slot count
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    occ <= (IDX_W+1)'(RS_ENTRIES));
  // R4: a dispatched slot has both operands ready
  a_r4_dispatch_ready: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> ((dispOneHot & bothRdy & validVec) != '0));
  // R7: the dispatched slot is empty after the edge
  a_r7_slot_freed: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |=> ((validVec & $past(dispOneHot)) == '0));
  // R8: an insert while full leaves the occupancy unchanged or lower
  a_r8_full_insert_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (full && insValid) |=> ($countones(validVec) <= RS_ENTRIES - 32'($past(dispValid))));
  // R1: nothing dispatched out of an empty station
  a_r1_empty_idle: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !dispValid);
endmodule

bind rsv_station rsv_station_chk u_chk (
  .clk(clk), .rstN(rstN), .insValid(insValid), .full(full), .dispValid(dispValid),
  .validVec(validVec), .bothRdy(bothRdy), .strobe(strobe)
);

// File: tb/test_rsv_station.sv
module test_rsv_station;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insValid = 0, insSrcARdy = 0, insSrcBRdy = 0, wbValid = 0;
  logic [3:0]  insOp = 0;
  logic [4:0]  insDstTag = 0, insSrcATag = 0, insSrcBTag = 0, wbTag = 0;
  logic [15:0] insSrcAVal = 0, insSrcBVal = 0, wbData = 0;
  logic        full, dispValid;
  logic [3:0]  dispOp;
  logic [4:0]  dispDstTag;
  logic [15:0] dispSrcA, dispSrcB;
  int          nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  rsv_station i_rsv_station (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic putIns(input logic [3:0] op, input logic [4:0] dst,
                        input logic ar, input logic [15:0] av, input logic [4:0] at,
                        input logic br, input logic [15:0] bv, input logic [4:0] bt);
    insValid = 1; insOp = op; insDstTag = dst;
    insSrcARdy = ar; insSrcAVal = av; insSrcATag = at;
    insSrcBRdy = br; insSrcBVal = bv; insSrcBTag = bt;
  endtask

  task automatic noIns(); insValid = 0; endtask
  task automatic putWb(input logic v, input logic [4:0] t, input logic [15:0] d);
    wbValid = v; wbTag = t; wbData = d;
  endtask

  task automatic chkDisp(input logic ev, input logic [3:0] op, input logic [4:0] dst,
                         input logic [15:0] a, input logic [15:0] b, input string req);
    nChecks++;
    if (dispValid !== ev || (ev && (dispOp !== op || dispDstTag !== dst ||
        dispSrcA !== a || dispSrcB !== b))) begin
      nFails++;
      $display("FAIL %s: dispatch got v=%b op=%0d dst=%0d a=%0d b=%0d, expected v=%b op=%0d dst=%0d a=%0d b=%0d",
               req, dispValid, dispOp, dispDstTag, dispSrcA, dispSrcB, ev, op, dst, a, b);
    end
  endtask

  task automatic chkFull(input logic ef, input string req);
    nChecks++;
    if (full !== ef) begin
      nFails++;
      $display("FAIL %s: full got %b expected %b", req, full, ef);
    end
  endtask

  task automatic testReset();
    chkFull(0, "R1");
    chkDisp(0, 0, 0, 0, 0, "R1");
  endtask

  task automatic testReadyInsert();
    putIns(1, 5, 1, 10, 0, 1, 20, 0); tick(); noIns();
    chkDisp(1, 1, 5, 10, 20, "R2");
    tick();
    chkDisp(0, 0, 0, 0, 0, "R7");
  endtask

  task automatic testWakeup();
    putIns(2, 6, 1, 3, 0, 0, 0, 9); tick(); noIns();
    chkDisp(0, 0, 0, 0, 0, "R4");
    putWb(1, 8, 77); tick();
    chkDisp(0, 0, 0, 0, 0, "R3 mismatched tag");
    putWb(0, 9, 55); tick();
    chkDisp(0, 0, 0, 0, 0, "R3 invalid bus");
    putWb(1, 9, 44); tick(); putWb(0, 0, 0);
    chkDisp(1, 2, 6, 3, 44, "R3");
    tick();
    chkDisp(0, 0, 0, 0, 0, "R7");
  endtask

  task automatic testBypass();
    putIns(3, 7, 0, 0, 4, 1, 1, 0); putWb(1, 4, 99); tick();
    noIns(); putWb(0, 0, 0);
    chkDisp(1, 3, 7, 99, 1, "R5");
    tick();
    chkDisp(0, 0, 0, 0, 0, "R5");
  endtask

  task automatic testAge();
    putIns(4, 1, 1, 11, 0, 1, 12, 0); tick();                // P -> slot 0
    chkDisp(1, 4, 1, 11, 12, "R2");
    putIns(5, 2, 0, 0, 20, 1, 2, 0); tick();                 // Q -> slot 1
    chkDisp(0, 0, 0, 0, 0, "R4");
    putIns(6, 3, 1, 3, 0, 0, 0, 20); tick(); noIns();        // R -> slot 0
    chkDisp(0, 0, 0, 0, 0, "R4");
    putWb(1, 20, 66); tick(); putWb(0, 0, 0);
    chkDisp(1, 5, 2, 66, 2, "R6 older in higher slot / R9");
    tick();
    chkDisp(1, 6, 3, 3, 66, "R6 / R9");
    tick();
    chkDisp(0, 0, 0, 0, 0, "R7");
  endtask

  task automatic testFull();
    for (int i = 0; i < 4; i++) begin
      putIns(4'(8 + i), 5'(8 + i), 0, 0, 30, 1, 16'(8 + i), 0); tick();
    end
    chkFull(1, "R8");
    putIns(15, 15, 1, 1, 0, 1, 1, 0); tick(); noIns();
    chkFull(1, "R8");
    chkDisp(0, 0, 0, 0, 0, "R8 dropped insert");
    putWb(1, 30, 5); tick(); putWb(0, 0, 0);
    chkDisp(1, 8, 8, 5, 8, "R9 / R6");
    chkFull(1, "R8");
    tick();
    chkFull(0, "R8");
    for (int i = 1; i < 4; i++) begin
      chkDisp(1, 4'(8 + i), 5'(8 + i), 5, 16'(8 + i), "R6 / R7");
      tick();
    end
    chkDisp(0, 0, 0, 0, 0, "R8 dropped insert");
  endtask

  initial begin
    #20; rstN = 1; #1;
    testReset();
    testReadyInsert();
    testWakeup();
    testBypass();
    testAge();
    testFull();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule